// File: doc/BRIEF.md
# Master Clock Ratio Auto-Detector

This block works out, with no configuration, how fast the master clock runs. It measures the master clock against an 8 kHz frame sync. It counts master-clock cycles from one frame-sync rising edge to the next. It then sorts that count into one of seven rate codes, each of which corresponds to a standard master-clock frequency. Using the chosen divisor, it produces a one-cycle enable at 256 kHz, which gives 32 enables in every frame.

One accepted rate gives 193 master cycles per frame, which does not divide evenly by 32. In that case the divider makes one of the 32 enable periods one cycle longer, so the enables stay locked to the frame.

A rate code only takes effect after two frames in a row agree on it. A frame that fits no code clears the lock flag but leaves the last code in place. The block can sit between a free-running master clock and the sequencing logic that runs on the 256 kHz enable, whatever PCM framing is in use.

Top module: `mcr_autodetect`

## Requirements
- R1: After reset, lock_o and tick_o are 0, rate_o is 0 and div_o is 1.
- R2: The rate codes are as follows: code 0 is 32 cycles per frame with divisor 1, code 1 is 64 with divisor 2, code 2 is 192 with divisor 6, code 3 is 193 with divisor 6, code 4 is 256 with divisor 8, code 5 is 320 with divisor 10 and code 6 is 512 with divisor 16. A count matches a code when it lies within 2 of that code's nominal count. Where two windows overlap, the nearer nominal count wins, so counts up to 192 give code 2 and counts from 193 give code 3. div_o always shows the divisor of rate_o.
- R3: A frame length is the number of clock edges from one frame-sync rising edge to the next. The first rising edge after reset only starts a measurement and leaves lock_o and rate_o unchanged.
- R4: lock_o rises, and rate_o and div_o take the new code, on the clock edge that ends the second consecutive frame matching the same code. lock_o and rate_o never change at any other edge than one that samples a frame-sync rising edge.
- R5: A frame that matches no code clears lock_o at the edge that ends it, and leaves rate_o and div_o unchanged.
- R6: A frame whose code differs from the previous frame's code clears lock_o and leaves rate_o unchanged. The next frame with the same code sets lock_o and switches rate_o.
- R7: While locked, tick_o is high for the edge that samples the frame-sync rise and again every div_o edges after it. A frame of exactly the nominal count gives exactly 32 ticks.
- R8: With code 3 locked, a 193-cycle frame gives 32 ticks. The first 31 gaps are 6 cycles each, and the last gap, up to the next frame's tick, is 7 cycles.
- R9: tick_o is 0 whenever lock_o is 0.
- R10: Only frame-sync rising edges matter. A frame-sync high time of one cycle and a high time of almost a whole frame give the same results.
- R11: The cycle counter saturates at 2^CNT_W-1 (2047 by default) and does not wrap. A frame longer than that matches no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync_i | input | 1 | 8 kHz frame sync, synchronous to clk_i |
| rate_o | output | 3 | Selected rate code |
| div_o | output | 5 | Divisor belonging to rate_o |
| lock_o | output | 1 | Two consecutive frames agreed on rate_o |
| tick_o | output | 1 | 256 kHz sequencing enable, one cycle wide |

## Verification
Two things happen on the same clock edge when a frame-sync rise is sampled. The detector makes its lock and rate decision, and the divider restarts its phase. On that edge tick_o must reflect the newly decided lock and divisor, not the old ones. The sweeps make this happen repeatedly. Each rate code is approached with frame lengths from 3 below to 3 above its nominal count, so lock is gained, lost and switched between codes exactly at frame edges. For each frame, the bench compares the tick positions and the tick count against spacing it computes from the code that should have been decided at that edge.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  localparam int unsigned NUM_RATES       = 7;
  localparam int unsigned TICKS_PER_FRAME = 32;
  localparam int unsigned MATCH_TOL       = 2;
  localparam int unsigned COUNT_W         = 11;
  localparam int unsigned RATE_W          = $clog2(NUM_RATES);
  localparam int unsigned IDX_W           = $clog2(TICKS_PER_FRAME);

  // master cycles per frame for each rate code, ascending
  function automatic int unsigned nominal_count(input int unsigned code);
    int unsigned n;
    case (code)
      0:       n = 32;
      1:       n = 64;
      2:       n = 192;
      3:       n = 193;
      4:       n = 256;
      5:       n = 320;
      6:       n = 512;
      default: n = 0;
    endcase
    return n;
  endfunction

  function automatic int unsigned divisor_of(input int unsigned code);
    return nominal_count(code) / TICKS_PER_FRAME;
  endfunction

  function automatic int unsigned remainder_of(input int unsigned code);
    return nominal_count(code) % TICKS_PER_FRAME;
  endfunction

  // lowest count accepted for a code; overlapping windows split at the midpoint
  function automatic int unsigned lo_bound(input int unsigned code, input int unsigned tol);
    int unsigned lo;
    int unsigned mid;
    lo = (nominal_count(code) > tol) ? nominal_count(code) - tol : 1;
    if (code > 0) begin
      mid = (nominal_count(code - 1) + nominal_count(code)) / 2 + 1;
      if (mid > lo) lo = mid;
    end
    return lo;
  endfunction

  function automatic int unsigned hi_bound(input int unsigned code, input int unsigned tol);
    int unsigned hi;
    int unsigned mid;
    hi = nominal_count(code) + tol;
    if (code + 1 < NUM_RATES) begin
      mid = (nominal_count(code) + nominal_count(code + 1)) / 2;
      if (mid < hi) hi = mid;
    end
    return hi;
  endfunction

  function automatic int unsigned max_divisor();
    int unsigned m;
    m = 0;
    for (int unsigned i = 0; i < NUM_RATES; i++) begin
      if (divisor_of(i) > m) m = divisor_of(i);
    end
    return m;
  endfunction

  localparam int unsigned DIV_W = $clog2(max_divisor() + 2);

endpackage

// File: rtl/mcr_reset_sync.sv
module mcr_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_no = stage1_q;

endmodule

// File: rtl/mcr_frame_meter.sv
module mcr_frame_meter #(
  parameter int unsigned CNT_W = mcr_pkg::COUNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             rise_o,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             fs_d_q;
  logic             seen_q;
  logic             seen_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    rise_o = fsync_i & ~fs_d_q;
    seen_d = seen_q | rise_o;
    if (rise_o) begin
      cnt_d = CNT_ONE;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_d_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fs_d_q <= fsync_i;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  assign meas_valid_o = rise_o & seen_q;
  assign count_o      = cnt_q;

endmodule

// File: rtl/mcr_rate_classifier.sv
module mcr_rate_classifier #(
  parameter int unsigned CNT_W     = mcr_pkg::COUNT_W,
  parameter int unsigned MATCH_TOL = mcr_pkg::MATCH_TOL,
  parameter int unsigned NUM_RATES = mcr_pkg::NUM_RATES,
  parameter int unsigned RATE_W    = mcr_pkg::RATE_W
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_o,
  output logic [RATE_W-1:0] code_o
);

  logic [NUM_RATES-1:0] win;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
    localparam int unsigned LO = mcr_pkg::lo_bound(g, MATCH_TOL);
    localparam int unsigned HI = mcr_pkg::hi_bound(g, MATCH_TOL);
    assign win[g] = (count_i >= CNT_W'(LO)) && (count_i <= CNT_W'(HI));
  end

  // windows are disjoint, so at most one bit of win is set
  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (win[i]) code_o = RATE_W'(i);
    end
    hit_o = |win;
  end

endmodule

// File: rtl/mcr_lock_ctrl.sv
module mcr_lock_ctrl #(
  parameter int unsigned RATE_W = mcr_pkg::RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_valid_i,
  input  logic              hit_i,
  input  logic [RATE_W-1:0] code_i,
  output logic [RATE_W-1:0] rate_q_o,
  output logic              lock_q_o,
  output logic [RATE_W-1:0] rate_d_o,
  output logic              lock_d_o
);

  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] rate_d;
  logic [RATE_W-1:0] cand_q;
  logic [RATE_W-1:0] cand_d;
  logic              cand_v_q;
  logic              cand_v_d;
  logic              lock_q;
  logic              lock_d;

  always_comb begin
    rate_d   = rate_q;
    cand_d   = cand_q;
    cand_v_d = cand_v_q;
    lock_d   = lock_q;
    if (meas_valid_i) begin
      if (!hit_i) begin
        lock_d   = 1'b0;
        cand_v_d = 1'b0;
      end else if (cand_v_q && (cand_q == code_i)) begin
        lock_d = 1'b1;
        rate_d = code_i;
      end else begin
        lock_d   = 1'b0;
        cand_d   = code_i;
        cand_v_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      cand_q   <= '0;
      cand_v_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      rate_q   <= rate_d;
      cand_q   <= cand_d;
      cand_v_q <= cand_v_d;
      lock_q   <= lock_d;
    end
  end

  assign rate_q_o = rate_q;
  assign lock_q_o = lock_q;
  assign rate_d_o = rate_d;
  assign lock_d_o = lock_d;

endmodule

// File: rtl/mcr_tick_gen.sv
module mcr_tick_gen #(
  parameter int unsigned NUM_RATES       = mcr_pkg::NUM_RATES,
  parameter int unsigned RATE_W          = mcr_pkg::RATE_W,
  parameter int unsigned TICKS_PER_FRAME = mcr_pkg::TICKS_PER_FRAME,
  parameter int unsigned IDX_W           = mcr_pkg::IDX_W,
  parameter int unsigned DIV_W           = mcr_pkg::DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              lock_d_i,
  input  logic [RATE_W-1:0] rate_d_i,
  output logic              tick_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TICKS_PER_FRAME - 1);
  localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] phase_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             tick_q;
  logic             tick_d;
  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] rem_sel;
  logic [DIV_W-1:0] eff_phase;
  logic [IDX_W-1:0] eff_idx;
  logic [DIV_W-1:0] limit;
  logic             wrap;

  always_comb begin
    div_sel = '0;
    rem_sel = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (rate_d_i == RATE_W'(i)) begin
        div_sel = DIV_W'(mcr_pkg::divisor_of(i));
        rem_sel = DIV_W'(mcr_pkg::remainder_of(i));
      end
    end
  end

  // a frame edge forces phase and period index back to zero
  always_comb begin
    eff_phase = rise_i ? '0 : phase_q;
    eff_idx   = rise_i ? '0 : idx_q;
    limit     = div_sel - DIV_ONE + ((eff_idx == IDX_LAST) ? rem_sel : '0);
    wrap      = (eff_phase == limit);
    phase_d   = wrap ? '0 : eff_phase + DIV_ONE;
    idx_d     = (wrap && (eff_idx != IDX_LAST)) ? eff_idx + IDX_W'(1) : eff_idx;
    tick_d    = lock_d_i && (eff_phase == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      idx_q   <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      tick_q  <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/mcr_autodetect.sv
module mcr_autodetect #(
  parameter int unsigned CNT_W     = mcr_pkg::COUNT_W,
  parameter int unsigned MATCH_TOL = mcr_pkg::MATCH_TOL
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fsync_i,
  output logic [mcr_pkg::RATE_W-1:0] rate_o,
  output logic [mcr_pkg::DIV_W-1:0]  div_o,
  output logic                       lock_o,
  output logic                       tick_o
);

  localparam int unsigned NUM_RATES = mcr_pkg::NUM_RATES;
  localparam int unsigned RATE_W    = mcr_pkg::RATE_W;
  localparam int unsigned DIV_W     = mcr_pkg::DIV_W;

  logic              rst_sync_n;
  logic              frame_rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  frame_count;
  logic              cls_hit;
  logic [RATE_W-1:0] cls_code;
  logic [RATE_W-1:0] rate_d;
  logic              lock_d;

  mcr_reset_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  mcr_frame_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .fsync_i      (fsync_i),
    .rise_o       (frame_rise),
    .meas_valid_o (meas_valid),
    .count_o      (frame_count)
  );

  mcr_rate_classifier #(
    .CNT_W     (CNT_W),
    .MATCH_TOL (MATCH_TOL),
    .NUM_RATES (NUM_RATES),
    .RATE_W    (RATE_W)
  ) u_class (
    .count_i (frame_count),
    .hit_o   (cls_hit),
    .code_o  (cls_code)
  );

  mcr_lock_ctrl #(.RATE_W(RATE_W)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .meas_valid_i (meas_valid),
    .hit_i        (cls_hit),
    .code_i       (cls_code),
    .rate_q_o     (rate_o),
    .lock_q_o     (lock_o),
    .rate_d_o     (rate_d),
    .lock_d_o     (lock_d)
  );

  mcr_tick_gen #(
    .NUM_RATES       (NUM_RATES),
    .RATE_W          (RATE_W),
    .TICKS_PER_FRAME (mcr_pkg::TICKS_PER_FRAME),
    .IDX_W           (mcr_pkg::IDX_W),
    .DIV_W           (DIV_W)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .rise_i   (frame_rise),
    .lock_d_i (lock_d),
    .rate_d_i (rate_d),
    .tick_o   (tick_o)
  );

  always_comb begin
    div_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (rate_o == RATE_W'(i)) div_o = DIV_W'(mcr_pkg::divisor_of(i));
    end
  end

endmodule

// File: rtl/mcr_autodetect_chk.sv
module mcr_autodetect_chk #(
  parameter int unsigned NUM_RATES = mcr_pkg::NUM_RATES,
  parameter int unsigned RATE_W    = mcr_pkg::RATE_W,
  parameter int unsigned DIV_W     = mcr_pkg::DIV_W
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              meas_valid,
  input logic              cls_hit,
  input logic [RATE_W-1:0] rate_o,
  input logic [DIV_W-1:0]  div_o,
  input logic              lock_o,
  input logic              tick_o
);

  assert_rate_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (int'(rate_o) < NUM_RATES) && (div_o != '0));

  assert_lock_at_match_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_o) |-> $past(meas_valid && cls_hit));

  assert_lock_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(lock_o) |-> $past(meas_valid));

  assert_nomatch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (meas_valid && !cls_hit) |=> (!lock_o && $stable(rate_o)));

  assert_rate_needs_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(rate_o) |-> lock_o);

  assert_tick_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |-> lock_o);

endmodule

bind mcr_autodetect mcr_autodetect_chk #(
  .NUM_RATES (mcr_pkg::NUM_RATES),
  .RATE_W    (mcr_pkg::RATE_W),
  .DIV_W     (mcr_pkg::DIV_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .meas_valid (meas_valid),
  .cls_hit    (cls_hit),
  .rate_o     (rate_o),
  .div_o      (div_o),
  .lock_o     (lock_o),
  .tick_o     (tick_o)
);

// File: tb/mcr_autodetect_tb_top.sv
module mcr_autodetect_tb_top;

  localparam int CNT_MAX = 2047;
  localparam int NOM[7]  = '{32, 64, 192, 193, 256, 320, 512};

  logic       clk;
  logic       rst_ni;
  logic       fsync;
  logic [2:0] rate_o;
  logic [4:0] div_o;
  logic       lock_o;
  logic       tick_o;

  int checks;
  int failures;
  bit done;

  int m_lock;
  int m_rate;
  int m_cand;
  int m_cand_v;
  int prev_len;
  bit first_meas;

  mcr_autodetect dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .fsync_i (fsync),
    .rate_o  (rate_o),
    .div_o   (div_o),
    .lock_o  (lock_o),
    .tick_o  (tick_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // nearest nominal count within a distance of 2, or -1
  function automatic int classify(input int len);
    int best;
    int bestd;
    best  = -1;
    bestd = 1000;
    for (int i = 0; i < 7; i++) begin
      int d;
      d = (len > NOM[i]) ? len - NOM[i] : NOM[i] - len;
      if (d <= 2 && d < bestd) begin
        best  = i;
        bestd = d;
      end
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fs);
    fsync = fs;
    @(negedge clk);
  endtask

  task automatic run_frame(input int len, input int hi_w);
    int    code;
    int    d;
    int    ticks;
    bit    bad;
    string tag;
    step(1'b1);
    tag = "R3";
    if (prev_len >= 0) begin
      code = classify(prev_len);
      if (code < 0) begin
        m_lock   = 0;
        m_cand_v = 0;
        tag      = (prev_len > CNT_MAX) ? "R11" : "R5";
      end else if (m_cand_v != 0 && m_cand == code) begin
        m_lock = 1;
        m_rate = code;
        tag    = "R4";
      end else begin
        m_lock   = 0;
        m_cand   = code;
        m_cand_v = 1;
        tag      = first_meas ? "R3" : "R6";
      end
      first_meas = 1'b0;
    end
    check(lock_o == 1'(m_lock), tag, "lock", int'(lock_o), m_lock);
    check(int'(rate_o) == m_rate, tag, "rate", int'(rate_o), m_rate);
    check(int'(div_o) == NOM[m_rate] / 32, "R2", "divisor", int'(div_o), NOM[m_rate] / 32);
    d     = NOM[m_rate] / 32;
    bad   = 1'b0;
    ticks = 0;
    for (int c = 0; c < len; c++) begin
      bit exp_t;
      if (c > 0) step(c < hi_w);
      ticks += int'(tick_o);
      exp_t = (m_lock != 0) && (c % d == 0) && (c / d < 32);
      if (tick_o != exp_t) bad = 1'b1;
    end
    if (m_lock == 0) begin
      check(ticks == 0, "R9", "ticks while unlocked", ticks, 0);
    end else if (len == NOM[m_rate]) begin
      check(!bad && ticks == 32, (m_rate == 3) ? "R8" : "R7", "tick pattern/count",
            bad ? -1 : ticks, 32);
    end
    prev_len = len;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks     = 0;
    failures   = 0;
    m_lock     = 0;
    m_rate     = 0;
    m_cand     = 0;
    m_cand_v   = 0;
    prev_len   = -1;
    first_meas = 1'b1;
    rst_ni     = 1'b0;
    fsync      = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(lock_o == 1'b0, "R1", "lock", int'(lock_o), 0);
    check(tick_o == 1'b0, "R1", "tick", int'(tick_o), 0);
    check(rate_o == 3'd0, "R1", "rate", int'(rate_o), 0);
    check(div_o == 5'd1, "R1", "divisor", int'(div_o), 1);

    // sweep every code over lengths nominal-3 .. nominal+3
    for (int code = 0; code < 7; code++) begin
      for (int dl = -3; dl <= 3; dl++) begin
        int len;
        int w;
        len = NOM[code] + dl;
        w   = (dl % 2 == 0) ? 1 : len / 2;
        run_frame(len, w);
        run_frame(len, w);
        run_frame(NOM[code], 1);
      end
    end

    // R10: frame-sync high time does not matter
    run_frame(64, 1);
    run_frame(64, 1);
    run_frame(64, 63);
    run_frame(64, 1);
    check(lock_o == 1'b1 && rate_o == 3'd1, "R10", "lock after long sync",
          int'(lock_o), 1);
    run_frame(64, 1);

    // R11: overlong frame saturates instead of wrapping to 32
    run_frame(32, 1);
    run_frame(32, 1);
    run_frame(32, 1);
    run_frame(2080, 1);
    run_frame(32, 1);
    check(lock_o == 1'b0 && rate_o == 3'd0, "R11", "lock after saturation",
          int'(lock_o), 0);
    run_frame(32, 1);
    run_frame(32, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule